// File: doc/BRIEF.md
# Reference Selection and Holdover Controller

This block sets the operating state of a digital clock-recovery loop that is fed by two redundant reference clocks. An activity monitor outside the block reports whether each reference is healthy. A control register picks which reference is used. The loop reports whether it is locked, and it sends its current frequency word on an update strobe. From these inputs the block chooses the state: free-run, acquiring, locked or holdover. It also picks the frequency word that drives the loop's oscillator: the fixed nominal word, the live loop word, or a stored holdover word.

While the loop is locked, the block averages the loop's frequency word over a fixed window of update strobes and keeps the result for holdover. If the selected reference fails, the block changes state on its own, with no software action. To leave holdover, software must select a reference that is healthy.

The frequency word arrives on a valid/ready stream. The block never applies back-pressure: `fw_ready` is always high. A word counts only in a cycle where `fw_valid` is high. Control and status pins are plain levels.

Top module: `refsel_holdover_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `state_o` is free-run, `sel_ref_o` is 0, `hold_valid_o` is 0 and `hold_word_o` is 0.
- R2: In free-run, `src_sel_o` is 0 (nominal) and `sel_ref_o` follows `sel_req`. When the requested reference is healthy, the state moves to acquiring on the next clock.
- R3: In acquiring, `src_sel_o` is 1 (live loop). The state moves to locked only on a clock where `lock_in` is high and the selected reference is healthy and still requested.
- R4: While the state stays locked, each cycle with `fw_valid` high adds `fw_data` to a running sum. After 2^WIN_LOG such strobes, `hold_word_o` takes the floor of sum / 2^WIN_LOG and `hold_valid_o` is set. A partial window is discarded whenever the state leaves locked. Cycles without a strobe are not counted.
- R5: If the selected reference fails while locked or acquiring and `hold_valid_o` is 1, the next state is holdover, and there `src_sel_o` is 2 (stored word).
- R6: If the selected reference fails while locked or acquiring and `hold_valid_o` is 0, the next state is free-run.
- R7: Holdover persists while `sel_req` equals `sel_ref_o`, even if that reference recovers or both references are lost. Requesting the other reference while it is healthy moves the state to acquiring on that reference. `hold_word_o` changes only during locked.
- R8: In locked, a drop of `lock_in` or a request for the other reference moves the state to acquiring. In the second case `sel_ref_o` becomes the requested reference.
- R9: State codes are 0 free-run, 1 acquiring, 2 locked and 3 holdover. `fw_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ok | input | 2 | Per-reference healthy flag from the activity monitor |
| sel_req | input | 1 | Register-driven manual reference request |
| lock_in | input | 1 | Loop lock indication |
| fw_valid | input | 1 | Frequency-word update strobe |
| fw_ready | output | 1 | Always 1; no back-pressure |
| fw_data | input | W | Loop frequency word |
| state_o | output | 2 | Operating state code |
| sel_ref_o | output | 1 | Reference in use |
| src_sel_o | output | 2 | Word mux select: 0 nominal, 1 live, 2 holdover |
| hold_word_o | output | W | Stored holdover average |
| hold_valid_o | output | 1 | A full window has been stored |

## Verification
The bench first drives a reference failure before any window has completed, which shows whether the block picks free-run or holdover (R6 against R5). Ramped words with idle gaps between strobes show whether the average uses true floor division and counts only strobes. Reference recovery and loss of both references while in holdover, set against a manual switch to a healthy reference, show whether only the software request can end holdover. A behavioural model is compared with the outputs on every clock throughout.

// File: rtl/rsh_pkg.sv
package rsh_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'b00,
    ST_ACQ  = 2'b01,
    ST_LOCK = 2'b10,
    ST_HOLD = 2'b11
  } rsh_state_e;

  typedef enum logic [1:0] {
    SRC_NOM  = 2'd0,
    SRC_LIVE = 2'd1,
    SRC_HOLD = 2'd2
  } rsh_src_e;
endpackage

// File: rtl/rsh_fsm.sv
module rsh_fsm
  import rsh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_ok,
  input  logic       sel_req,
  input  logic       lock_in,
  input  logic       hold_valid,
  output rsh_state_e state,
  output logic       cur_ref,
  output logic       avg_en
);
  rsh_state_e nxt;
  logic       nref;
  logic       cur_ok;
  logic       req_ok;

  assign cur_ok = ref_ok[cur_ref];
  assign req_ok = ref_ok[sel_req];

  always_comb begin
    nxt  = state;
    nref = cur_ref;
    unique case (state)
      ST_FREE: begin
        nref = sel_req;
        if (req_ok) nxt = ST_ACQ;
      end
      ST_ACQ: begin
        if (!cur_ok)                nxt = hold_valid ? ST_HOLD : ST_FREE;
        else if (sel_req != cur_ref) nref = sel_req;
        else if (lock_in)            nxt = ST_LOCK;
      end
      ST_LOCK: begin
        if (!cur_ok) nxt = hold_valid ? ST_HOLD : ST_FREE;
        else if (sel_req != cur_ref) begin
          nref = sel_req;
          nxt  = ST_ACQ;
        end else if (!lock_in) nxt = ST_ACQ;
      end
      ST_HOLD: begin
        if (sel_req != cur_ref && req_ok) begin
          nref = sel_req;
          nxt  = ST_ACQ;
        end
      end
      default: nxt = ST_FREE;
    endcase
  end

  assign avg_en = (state == ST_LOCK) && cur_ok && (sel_req == cur_ref) && lock_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_FREE;
      cur_ref <= 1'b0;
    end else begin
      state   <= nxt;
      cur_ref <= nref;
    end
  end
endmodule

// File: rtl/rsh_avg.sv
module rsh_avg #(
  parameter int W       = 32,
  parameter int WIN_LOG = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         avg_en,
  input  logic         fw_valid,
  input  logic [W-1:0] fw_data,
  output logic [W-1:0] hold_word,
  output logic         hold_valid
);
  localparam int ACC_W = W + WIN_LOG;
  localparam logic [WIN_LOG-1:0] LAST = {WIN_LOG{1'b1}};

  logic [ACC_W-1:0]   acc;
  logic [ACC_W-1:0]   sum;
  logic [WIN_LOG-1:0] cnt;

  assign sum = acc + {{WIN_LOG{1'b0}}, fw_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      cnt        <= '0;
      hold_word  <= '0;
      hold_valid <= 1'b0;
    end else if (!avg_en) begin
      acc <= '0;
      cnt <= '0;
    end else if (fw_valid) begin
      if (cnt == LAST) begin
        hold_word  <= sum[ACC_W-1:WIN_LOG];
        hold_valid <= 1'b1;
        acc        <= '0;
        cnt        <= '0;
      end else begin
        acc <= sum;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsh_srcmap.sv
module rsh_srcmap
  import rsh_pkg::*;
(
  input  rsh_state_e state,
  output rsh_src_e   src
);
  always_comb begin
    unique case (state)
      ST_FREE: src = SRC_NOM;
      ST_HOLD: src = SRC_HOLD;
      default: src = SRC_LIVE;
    endcase
  end
endmodule

// File: rtl/refsel_holdover_ctrl.sv
module refsel_holdover_ctrl
  import rsh_pkg::*;
#(
  parameter int W       = 32,
  parameter int WIN_LOG = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   ref_ok,
  input  logic         sel_req,
  input  logic         lock_in,
  input  logic         fw_valid,
  output logic         fw_ready,
  input  logic [W-1:0] fw_data,
  output logic [1:0]   state_o,
  output logic         sel_ref_o,
  output logic [1:0]   src_sel_o,
  output logic [W-1:0] hold_word_o,
  output logic         hold_valid_o
);
  rsh_state_e st;
  rsh_src_e   src;
  logic       avg_en;

  rsh_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .sel_req(sel_req),
    .lock_in(lock_in), .hold_valid(hold_valid_o),
    .state(st), .cur_ref(sel_ref_o), .avg_en(avg_en)
  );

  rsh_avg #(.W(W), .WIN_LOG(WIN_LOG)) u_avg (
    .clk(clk), .rst_n(rst_n), .avg_en(avg_en), .fw_valid(fw_valid),
    .fw_data(fw_data), .hold_word(hold_word_o), .hold_valid(hold_valid_o)
  );

  rsh_srcmap u_map (.state(st), .src(src));

  assign state_o   = st;
  assign src_sel_o = src;
  assign fw_ready  = 1'b1;
endmodule

// File: rtl/refsel_holdover_ctrl_chk.sv
module refsel_holdover_ctrl_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   ref_ok,
  input logic         sel_req,
  input logic         lock_in,
  input logic [1:0]   state_o,
  input logic         sel_ref_o,
  input logic [1:0]   src_sel_o,
  input logic [W-1:0] hold_word_o,
  input logic         hold_valid_o
);
  assert_fail_to_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b10 && !ref_ok[sel_ref_o] && hold_valid_o) |=> (state_o == 2'b11));

  assert_fail_to_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b10 && !ref_ok[sel_ref_o] && !hold_valid_o) |=> (state_o == 2'b00));

  assert_hold_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b11 && sel_req == sel_ref_o) |=> (state_o == 2'b11));

  assert_word_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'b10) |=> $stable(hold_word_o));

  assert_no_lock_without_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b01 && !lock_in) |=> (state_o != 2'b10));

  assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(hold_valid_o));

  assert_hold_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b11) |-> (src_sel_o == 2'd2));
endmodule

bind refsel_holdover_ctrl refsel_holdover_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .sel_req(sel_req),
  .lock_in(lock_in), .state_o(state_o), .sel_ref_o(sel_ref_o),
  .src_sel_o(src_sel_o), .hold_word_o(hold_word_o), .hold_valid_o(hold_valid_o)
);

// File: tb/refsel_holdover_ctrl_tb_top.sv
`timescale 1ns/1ps
module refsel_holdover_ctrl_tb_top;
  localparam int W = 32;
  localparam int WL = 4;
  localparam int WIN = 1 << WL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ref_ok = 2'b00;
  logic sel_req = 1'b0;
  logic lock_in = 1'b0;
  logic fw_valid = 1'b0;
  logic [W-1:0] fw_data = '0;
  logic fw_ready;
  logic [1:0] state_o;
  logic sel_ref_o;
  logic [1:0] src_sel_o;
  logic [W-1:0] hold_word_o;
  logic hold_valid_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  refsel_holdover_ctrl #(.W(W), .WIN_LOG(WL)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .sel_req(sel_req),
    .lock_in(lock_in), .fw_valid(fw_valid), .fw_ready(fw_ready),
    .fw_data(fw_data), .state_o(state_o), .sel_ref_o(sel_ref_o),
    .src_sel_o(src_sel_o), .hold_word_o(hold_word_o), .hold_valid_o(hold_valid_o)
  );

  // behavioural model: 0 free,1 acq,2 lock,3 hold
  int m_st = 0, m_ref = 0, m_hv = 0, m_cnt = 0;
  longint m_acc = 0, m_hw = 0;

  always @(posedge clk) begin
    int ns, nr, ok, rok, stay;
    if (!rst_n) begin
      m_st = 0; m_ref = 0; m_hv = 0; m_cnt = 0; m_acc = 0; m_hw = 0;
    end else begin
      ns = m_st; nr = m_ref;
      ok = ref_ok[m_ref]; rok = ref_ok[sel_req];
      stay = (m_st == 2 && ok && sel_req == m_ref && lock_in) ? 1 : 0;
      if (m_st == 0) begin
        nr = sel_req; if (rok) ns = 1;
      end else if (m_st == 1 || m_st == 2) begin
        if (!ok) ns = m_hv ? 3 : 0;
        else if (sel_req != m_ref) begin nr = sel_req; if (m_st == 2) ns = 1; end
        else if (m_st == 1 && lock_in) ns = 2;
        else if (m_st == 2 && !lock_in) ns = 1;
      end else if (sel_req != m_ref && rok) begin
        nr = sel_req; ns = 1;
      end
      if (!stay) begin m_acc = 0; m_cnt = 0; end
      else if (fw_valid) begin
        m_acc += longint'(fw_data); m_cnt++;
        if (m_cnt == WIN) begin m_hw = m_acc / WIN; m_hv = 1; m_acc = 0; m_cnt = 0; end
      end
      m_st = ns; m_ref = nr;
    end
  end

  task automatic cmp(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    cmp("R9 state vs model", state_o, m_st);
    cmp("R2 sel_ref vs model", sel_ref_o, m_ref);
    cmp("R2 src_sel vs model", src_sel_o, (m_st == 0) ? 0 : (m_st == 3) ? 2 : 1);
    cmp("R4 hold_valid vs model", hold_valid_o, m_hv);
    cmp("R4 hold_word vs model", hold_word_o, m_hw);
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(int v, bit gap);
    fw_valid = 1'b1; fw_data = W'(v);
    @(negedge clk);
    fw_valid = 1'b0;
    if (gap) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    cyc(3);
    cmp("R1 reset state", state_o, 0);
    cmp("R1 reset hold_valid", hold_valid_o, 0);
    rst_n = 1'b1;
    cyc(1);
    cmp("R1 state after reset", state_o, 0);
    cmp("R1 sel_ref after reset", sel_ref_o, 0);
    cmp("R1 hold_word after reset", hold_word_o, 0);
    cmp("R9 fw_ready high", fw_ready, 1);
    // free-run follows request
    sel_req = 1'b1; cyc(1);
    cmp("R2 sel_ref follows request in free-run", sel_ref_o, 1);
    sel_req = 1'b0; cyc(1);
    ref_ok = 2'b01; cyc(1);
    cmp("R2 enter acquiring", state_o, 1);
    cyc(4);
    cmp("R3 no lock without flag", state_o, 1);
    cmp("R3 acquiring uses live word", src_sel_o, 1);
    lock_in = 1'b1; cyc(1);
    cmp("R3 locked on flag", state_o, 2);
    // failure before a window completes
    strobe(50, 0); strobe(60, 0); strobe(70, 0);
    ref_ok = 2'b00; cyc(1);
    cmp("R6 early failure goes free-run", state_o, 0);
    cmp("R6 no holdover value", hold_valid_o, 0);
    ref_ok = 2'b01; cyc(2);
    cmp("R3 relocked", state_o, 2);
    for (int i = 0; i < WIN; i++) strobe(100 + i, (i % 3) == 0);
    cmp("R4 window average floor", hold_word_o, 107);
    cmp("R4 hold_valid set", hold_valid_o, 1);
    for (int i = 0; i < WIN; i++) strobe(2000, 0);
    cmp("R4 second window", hold_word_o, 2000);
    lock_in = 1'b0; cyc(1);
    cmp("R8 lock loss to acquiring", state_o, 1);
    lock_in = 1'b1; cyc(1);
    strobe(9999, 0); strobe(9999, 0);
    ref_ok = 2'b00; cyc(1);
    cmp("R5 failure enters holdover", state_o, 3);
    cmp("R5 holdover uses stored word", src_sel_o, 2);
    cmp("R7 partial window discarded", hold_word_o, 2000);
    ref_ok = 2'b01; cyc(5);
    cmp("R7 holdover persists on recovery", state_o, 3);
    ref_ok = 2'b11; cyc(3);
    cmp("R7 holdover persists without request", state_o, 3);
    sel_req = 1'b1; cyc(1);
    cmp("R7 manual switch to acquiring", state_o, 1);
    cmp("R7 switched reference", sel_ref_o, 1);
    cyc(1);
    cmp("R3 locked on reference 1", state_o, 2);
    sel_req = 1'b0; cyc(1);
    cmp("R8 switch while locked", state_o, 1);
    cmp("R8 new reference", sel_ref_o, 0);
    ref_ok = 2'b00; cyc(1);
    cmp("R5 acquiring failure to holdover", state_o, 3);
    sel_req = 1'b1; cyc(50);
    cmp("R7 both lost stays in holdover", state_o, 3);
    cmp("R7 stored word kept", hold_word_o, 2000);
    rst_n = 1'b0; cyc(1);
    cmp("R1 reset clears holdover valid", hold_valid_o, 0);
    cmp("R1 reset to free-run", state_o, 0);
    cyc(2);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end
endmodule